// File: doc/BRIEF.md
# PHY XS Control and Receive Status Register Bank

This block holds the management-visible registers for the PHY XS side of a four-lane transceiver. Two control registers drive the line side. One sets a 3-bit transmit pre-emphasis level for each lane. The other sets a 4-bit receive equalizer boost, where code 0x0 means no boost and 0xF means maximum boost. A third register collects receive-path faults. Each lane has a sticky flag for elasticity FIFO overflow or underflow and a sticky flag for BIST mismatches. Each flag latches on a one-cycle event pulse and clears when it is read.

Management access uses a single-cycle request strobe that carries a device number, a 16-bit register address and write data. Read data appears on a registered output one clock after the strobe and holds until the next read. An auto-configure port can reload both control registers in any cycle. A read of the alarm-status register, which sits in another device (device 1, address 0x9004), also clears the fault flags held here.

Top module: `phyxs_regbank`

## Requirements
- R1: After reset, every control field and every status flag is 0, and `rd_data` is 0.
- R2: A write to device 4, address 0xC005 stores the pre-emphasis level of lane n in bits 3n+2:3n (lane 0 in bits 2:0, lane 3 in bits 11:9). A read of that address returns the stored fields, and bits 15:12 read as 0.
- R3: A write to device 4, address 0xC006 stores the equalizer boost in bits 3:0. A read returns it, and bits 15:4 read as 0.
- R4: A read of device 4, address 0xC007 returns the status word. Bit 4+n is the FIFO-error flag of lane n, bit n is the BIST-error flag of lane n, and bits 15:8 read as 0.
- R5: An event pulse on `efifo_evt[n]` or `bist_evt[n]` sets the matching flag, and the flag stays set until a clearing read.
- R6: A status read returns the flag values from before the read, and then all flags are cleared.
- R7: A read of device 1, address 0x9004 clears all flags and returns 0 on `rd_data`.
- R8: An event that arrives in the same cycle as a clearing read leaves its flag set after that read.
- R9: When `acfg_load` is high, `acfg_preemph` and `acfg_eq` are loaded into the control registers. If a management write to the same register happens in the same cycle, the auto-configure value wins.
- R10: Writes to the status register, and writes to reserved bits, have no effect. A write to any device other than 4 has no effect.
- R11: A read of an unmapped address returns 0 one clock later and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device number |
| req_addr | input | 16 | Register address |
| req_wdata | input | DATA_W | Write data |
| acfg_load | input | 1 | Auto-configure load strobe |
| acfg_preemph | input | LANES*PE_W | Pre-emphasis levels to load |
| acfg_eq | input | EQ_W | Equalizer boost to load |
| efifo_evt | input | LANES | Per-lane elasticity FIFO error pulses |
| bist_evt | input | LANES | Per-lane BIST error pulses |
| rd_data | output | DATA_W | Registered read data |

## Verification
The hardest case to reach is a fault pulse that arrives in exactly the cycle when a clearing read samples the flags. The read data must show the old flags, and the flags left behind must hold only the new event. The bench reaches this case by driving the event inputs inside the same access task as the status read, so both are applied at the same clock edge. It then reads the status register a second time to see what remains. The same approach puts an auto-configure load and a management write in one cycle, to check that the load wins.

// File: rtl/phyxs_pkg.sv
package phyxs_pkg;
    localparam logic [4:0]  DEV_XS       = 5'd4;
    localparam logic [4:0]  DEV_PMA      = 5'd1;
    localparam logic [15:0] ADR_PREEMPH  = 16'hC005;
    localparam logic [15:0] ADR_EQ       = 16'hC006;
    localparam logic [15:0] ADR_RXSTAT   = 16'hC007;
    localparam logic [15:0] ADR_ALARM    = 16'h9004;

    typedef struct packed {
        logic pe_wr;
        logic eq_wr;
        logic pe_rd;
        logic eq_rd;
        logic stat_rd;
        logic alarm_rd;
        logic any_rd;
    } hit_t;
endpackage

// File: rtl/phyxs_decode.sv
module phyxs_decode
    import phyxs_pkg::*;
(
    input  logic        valid,
    input  logic        write,
    input  logic [4:0]  dev,
    input  logic [15:0] addr,
    output hit_t        hit
);
    logic xs_dev;
    logic rd;
    logic wr;

    always_comb begin
        xs_dev       = (dev == DEV_XS);
        rd           = valid && !write;
        wr           = valid && write;
        hit          = '0;
        hit.pe_wr    = wr && xs_dev && (addr == ADR_PREEMPH);
        hit.eq_wr    = wr && xs_dev && (addr == ADR_EQ);
        hit.pe_rd    = rd && xs_dev && (addr == ADR_PREEMPH);
        hit.eq_rd    = rd && xs_dev && (addr == ADR_EQ);
        hit.stat_rd  = rd && xs_dev && (addr == ADR_RXSTAT);
        hit.alarm_rd = rd && (dev == DEV_PMA) && (addr == ADR_ALARM);
        hit.any_rd   = rd;
    end
endmodule

// File: rtl/phyxs_flag_latch.sv
module phyxs_flag_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        // a clear removes old state, but events of this cycle still land
        if (clr_i) flags_d = set_i;
        else       flags_d = flags_q | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/phyxs_regbank.sv
module phyxs_regbank
    import phyxs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PE_W   = 3,
    parameter int EQ_W   = 4,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [4:0]              req_dev,
    input  logic [15:0]             req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic                    acfg_load,
    input  logic [LANES*PE_W-1:0]   acfg_preemph,
    input  logic [EQ_W-1:0]         acfg_eq,
    input  logic [LANES-1:0]        efifo_evt,
    input  logic [LANES-1:0]        bist_evt,
    output logic [DATA_W-1:0]       rd_data
);
    localparam int PE_BITS   = LANES * PE_W;
    localparam int STAT_BITS = 2 * LANES;

    typedef struct packed {
        logic [PE_BITS-1:0] pe;
        logic [EQ_W-1:0]    eq;
        logic [DATA_W-1:0]  rdata;
    } state_t;

    state_t st_d, st_q;
    hit_t   hit;

    logic [PE_BITS-1:0]   pe_bus;
    logic [EQ_W-1:0]      eq_bus;
    logic [STAT_BITS-1:0] stat_bus;
    logic [DATA_W-1:0]    stat_word;
    logic [DATA_W-1:0]    pe_word;
    logic [DATA_W-1:0]    eq_word;

    phyxs_decode u_dec (
        .valid (req_valid),
        .write (req_write),
        .dev   (req_dev),
        .addr  (req_addr),
        .hit   (hit)
    );

    // upper half: FIFO errors, lower half: BIST errors
    phyxs_flag_latch #(.W(STAT_BITS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   ({efifo_evt, bist_evt}),
        .clr_i   (hit.stat_rd || hit.alarm_rd),
        .flags_o (stat_bus)
    );

    assign pe_bus    = st_q.pe;
    assign eq_bus    = st_q.eq;
    assign pe_word   = {{(DATA_W-PE_BITS){1'b0}}, st_q.pe};
    assign eq_word   = {{(DATA_W-EQ_W){1'b0}}, st_q.eq};
    assign stat_word = {{(DATA_W-STAT_BITS){1'b0}}, stat_bus};

    always_comb begin
        st_d = st_q;
        if (hit.pe_wr) st_d.pe = req_wdata[PE_BITS-1:0];
        if (hit.eq_wr) st_d.eq = req_wdata[EQ_W-1:0];
        if (acfg_load) begin
            st_d.pe = acfg_preemph;
            st_d.eq = acfg_eq;
        end
        if (hit.any_rd) begin
            if (hit.pe_rd)        st_d.rdata = pe_word;
            else if (hit.eq_rd)   st_d.rdata = eq_word;
            else if (hit.stat_rd) st_d.rdata = stat_word;
            else                  st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;
endmodule

// File: rtl/phyxs_regbank_chk.sv
module phyxs_regbank_chk
    import phyxs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PE_W   = 3,
    parameter int EQ_W   = 4,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [4:0]            req_dev,
    input logic [15:0]           req_addr,
    input logic                  acfg_load,
    input logic [LANES*PE_W-1:0] acfg_preemph,
    input logic [EQ_W-1:0]       acfg_eq,
    input logic [LANES-1:0]      efifo_evt,
    input logic [LANES-1:0]      bist_evt,
    input logic [DATA_W-1:0]     rd_data,
    input logic [LANES*PE_W-1:0] pe_q,
    input logic [EQ_W-1:0]       eq_q,
    input logic [2*LANES-1:0]    stat_q
);
    logic [2*LANES-1:0] ev;
    logic rd_op, stat_rd, alarm_rd, clr, mapped;

    assign ev       = {efifo_evt, bist_evt};
    assign rd_op    = req_valid && !req_write;
    assign stat_rd  = rd_op && req_dev == DEV_XS && req_addr == ADR_RXSTAT;
    assign alarm_rd = rd_op && req_dev == DEV_PMA && req_addr == ADR_ALARM;
    assign clr      = stat_rd || alarm_rd;
    assign mapped   = req_dev == DEV_XS &&
                      (req_addr == ADR_PREEMPH || req_addr == ADR_EQ || req_addr == ADR_RXSTAT);

    a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));

    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev == '0) |=> stat_q == '0);

    a_r8_event_survives: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> stat_q == $past(ev));

    a_r6_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> rd_data == {{(DATA_W-2*LANES){1'b0}}, $past(stat_q)});

    a_r9_acfg_wins: assert property (@(posedge clk) disable iff (!rst_n)
        acfg_load |=> (pe_q == $past(acfg_preemph) && eq_q == $past(acfg_eq)));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_op && !mapped) |=> rd_data == '0);
endmodule

bind phyxs_regbank phyxs_regbank_chk #(
    .LANES(LANES), .PE_W(PE_W), .EQ_W(EQ_W), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_dev      (req_dev),
    .req_addr     (req_addr),
    .acfg_load    (acfg_load),
    .acfg_preemph (acfg_preemph),
    .acfg_eq      (acfg_eq),
    .efifo_evt    (efifo_evt),
    .bist_evt     (bist_evt),
    .rd_data      (rd_data),
    .pe_q         (pe_bus),
    .eq_q         (eq_bus),
    .stat_q       (stat_bus)
);

// File: tb/phyxs_regbank_test.sv
module phyxs_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        acfg_load = 1'b0;
    logic [11:0] acfg_preemph = '0;
    logic [3:0]  acfg_eq = '0;
    logic [3:0]  efifo_evt = '0;
    logic [3:0]  bist_evt = '0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    phyxs_regbank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dev(req_dev), .req_addr(req_addr), .req_wdata(req_wdata),
        .acfg_load(acfg_load), .acfg_preemph(acfg_preemph), .acfg_eq(acfg_eq),
        .efifo_evt(efifo_evt), .bist_evt(bist_evt), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  dev;
        logic [15:0] addr;
        logic [15:0] wd;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd4, 16'hC005, 16'hFABC, 16'h0000}, // R2 write, reserved bits set
        '{1'b0, 5'd4, 16'hC005, 16'h0000, 16'h0ABC}, // R2 readback, R10 reserved dropped
        '{1'b1, 5'd4, 16'hC006, 16'hFFF5, 16'h0000}, // R3 write
        '{1'b0, 5'd4, 16'hC006, 16'h0000, 16'h0005}, // R3 readback
        '{1'b1, 5'd4, 16'hC007, 16'hFFFF, 16'h0000}, // R10 status write
        '{1'b0, 5'd4, 16'hC007, 16'h0000, 16'h0000}, // R10 status unchanged
        '{1'b0, 5'd4, 16'hC004, 16'h0000, 16'h0000}, // R11 unmapped
        '{1'b1, 5'd3, 16'hC005, 16'h1234, 16'h0000}, // R10 other device
        '{1'b0, 5'd4, 16'hC005, 16'h0000, 16'h0ABC}, // R10 unchanged
        '{1'b0, 5'd1, 16'h9004, 16'h0000, 16'h0000}  // R7 alarm read data
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge; drives one cycle and returns at the next falling edge
    task automatic op(input logic v, input logic w, input logic [4:0] d, input logic [15:0] a,
                      input logic [15:0] wd, input logic [3:0] ef, input logic [3:0] bi,
                      input logic ld, input logic [11:0] lpe, input logic [3:0] leq);
        req_valid = v; req_write = w; req_dev = d; req_addr = a; req_wdata = wd;
        efifo_evt = ef; bist_evt = bi;
        acfg_load = ld; acfg_preemph = lpe; acfg_eq = leq;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; efifo_evt = '0; bist_evt = '0; acfg_load = 1'b0;
    endtask

    task automatic rd(input logic [4:0] d, input logic [15:0] a);
        op(1'b1, 1'b0, d, a, 16'h0, 4'h0, 4'h0, 1'b0, 12'h0, 4'h0);
    endtask

    task automatic evt(input logic [3:0] ef, input logic [3:0] bi);
        op(1'b0, 1'b0, 5'd0, 16'h0, 16'h0, ef, bi, 1'b0, 12'h0, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, 16'h0000);
        rd(5'd4, 16'hC005); check("R1 preemph reset", rd_data, 16'h0000);
        rd(5'd4, 16'hC006); check("R1 eq reset", rd_data, 16'h0000);
        rd(5'd4, 16'hC007); check("R1 status reset", rd_data, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            op(1'b1, VECS[i].wr, VECS[i].dev, VECS[i].addr, VECS[i].wd,
               4'h0, 4'h0, 1'b0, 12'h0, 4'h0);
            if (!VECS[i].wr) check($sformatf("vector %0d", i), rd_data, VECS[i].exp);
        end

        // R4/R5: layout and hold
        evt(4'b0101, 4'b0010);
        evt(4'b0000, 4'b0000);
        evt(4'b0000, 4'b0000);
        rd(5'd4, 16'hC007); check("R4 R5 status layout and hold", rd_data, 16'h0052);
        rd(5'd4, 16'hC007); check("R6 cleared after read", rd_data, 16'h0000);

        // R8: event coincides with a status read
        evt(4'b0000, 4'b1000);
        op(1'b1, 1'b0, 5'd4, 16'hC007, 16'h0, 4'b0001, 4'b0000, 1'b0, 12'h0, 4'h0);
        check("R8 read shows pre-read flags", rd_data, 16'h0008);
        rd(5'd4, 16'hC007); check("R8 coincident event kept", rd_data, 16'h0010);

        // R7: alarm read clears
        evt(4'b1000, 4'b0100);
        rd(5'd1, 16'h9004); check("R7 alarm read data", rd_data, 16'h0000);
        rd(5'd4, 16'hC007); check("R7 flags cleared by alarm read", rd_data, 16'h0000);

        // R11: unmapped read leaves flags
        evt(4'b0000, 4'b0001);
        rd(5'd4, 16'hC008); check("R11 unmapped read zero", rd_data, 16'h0000);
        rd(5'd4, 16'hC007); check("R11 flags untouched", rd_data, 16'h0001);

        // R9: auto-configure load, and collision with a write
        op(1'b0, 1'b0, 5'd0, 16'h0, 16'h0, 4'h0, 4'h0, 1'b1, 12'h123, 4'h9);
        rd(5'd4, 16'hC005); check("R9 acfg preemph", rd_data, 16'h0123);
        rd(5'd4, 16'hC006); check("R9 acfg eq", rd_data, 16'h0009);
        op(1'b1, 1'b1, 5'd4, 16'hC005, 16'h0777, 4'h0, 4'h0, 1'b1, 12'h456, 4'h3);
        rd(5'd4, 16'hC005); check("R9 acfg beats write", rd_data, 16'h0456);
        op(1'b1, 1'b1, 5'd4, 16'hC006, 16'h000C, 4'h0, 4'h0, 1'b1, 12'h456, 4'hE);
        rd(5'd4, 16'hC006); check("R9 acfg beats eq write", rd_data, 16'h000E);

        // R2: each lane field alone
        for (int ln = 0; ln < 4; ln++) begin
            op(1'b1, 1'b1, 5'd4, 16'hC005, 16'(3'd5) << (3*ln), 4'h0, 4'h0, 1'b0, 12'h0, 4'h0);
            rd(5'd4, 16'hC005);
            check($sformatf("R2 lane %0d field", ln), rd_data, 16'(3'd5) << (3*ln));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule